// File: doc/BRIEF.md
# Serial Command Register Port

This block is a slave control port for a four-channel line interface. A host reaches it over four wires: an active-low select, a serial clock, serial data in and serial data out. Through this port the host can write and read a small bank of per-channel command registers. The register bits drive the per-channel control outputs: transmitter shutdown, all-ones transmit, transmit clock edge, line build-out, equalizer enable, the two loss-of-signal detector disables, single-rail output, LOS muting, receiver shutdown, receive clock inversion and the loopback choice. One register per channel returns live status: loss of signal, analog LOS, digital LOS and drive-monitor alarm.

The serial pins are oversampled in the core clock domain. Each frame lasts exactly sixteen serial clocks. The first eight bits are a command byte, which holds a direction bit and a five-bit register address. The last eight bits carry data, and only five of them are meaningful. A write takes effect only when the whole frame has arrived. If the host raises the select line early, the frame is dropped. During a read, the port drives its data pin only in the data phase. At all other times it signals that the pin is released.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is sampled on rising serial clock edges while cs_n is low. Frame bit 0 is the direction (1 = read, 0 = write). Bits 1 to 5 carry address bits A0 to A4, lowest first. Bits 6 and 7 are ignored. Bits 8 to 15 carry data D0 to D7, lowest first.
- R2: Address bits A4:A3 select the channel and A2:A0 select the register within that channel. Channel n therefore occupies addresses 8n to 8n+7.
- R3: On a read, sdo changes after falling serial clock edges. The host samples D0 to D4 at the rising edges of frame bits 8 to 12. Frame bits 13 to 15 read as 0.
- R4: sdo_oe is high only during the data phase of a read. It drops when the sixteenth bit is taken or when cs_n goes high.
- R5: Register 0 of each channel is read-only status: bit0 LOS, bit1 analog LOS, bit2 digital LOS, bit3 drive-monitor alarm, bit4 zero. Writes to it have no effect.
- R6: Registers 1 to 4 of each channel are read/write with these writable-bit masks: 0x0F, 0x07, 0x0F and 0x03. Masked-off bits read 0. Registers 5 to 7 read 0 and ignore writes. Data bits D5 to D7 are discarded.
- R7: The control outputs mirror the registers. Register 1 of channel c appears on tx_cfg_o[5c+4:5c]. Register 2 appears on rxl_cfg_o, register 3 on rxo_cfg_o and register 4 on loop_cfg_o, at the same slice.
- R8: A write commits only on the sixteenth bit. If cs_n rises before that, no register changes.
- R9: A reg_rst pulse returns every control register to its default: register 2 = 0x01 (equalizer on), all others 0.
- R10: Serial clocks after the sixteenth bit, while cs_n stays low, change no register and do not re-enable sdo_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rst | input | 1 | Synchronous register reset to defaults |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | High while sdo should be driven onto the pin |
| los_i | input | NCH | Per-channel loss of signal |
| alos_i | input | NCH | Per-channel analog LOS |
| dlos_i | input | NCH | Per-channel digital LOS |
| dmo_i | input | NCH | Per-channel drive-monitor alarm |
| tx_cfg_o | output | NCH*5 | Transmit controls per channel (register 1) |
| rxl_cfg_o | output | NCH*5 | Receive line controls per channel (register 2) |
| rxo_cfg_o | output | NCH*5 | Receive output controls per channel (register 3) |
| loop_cfg_o | output | NCH*5 | Loopback controls per channel (register 4) |

## Verification
The hardest state to reach is a frame cut short after the data phase has begun but before the sixteenth bit. Reaching it needs a select edge timed against the serial clock rather than a complete transfer. The bench drives a twelve-bit write frame, raises cs_n, and then reads the target back to confirm the old contents survived. It also drives frames that run past sixteen clocks to confirm that the extra bits are ignored. It sweeps all 32 addresses twice with different data and status patterns, so every masked, reserved and read-only location is written and read.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int REG_W = 5;
    localparam int NCTL  = 4;

    function automatic logic [REG_W-1:0] ctl_mask(input int k);
        case (k)
            0:       return 5'h0F;
            1:       return 5'h07;
            2:       return 5'h0F;
            3:       return 5'h03;
            default: return 5'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] ctl_default(input int k);
        return (k == 1) ? 5'h01 : 5'h00;
    endfunction
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i] <= RST_VAL[i];
                sync_q[i] <= RST_VAL[i];
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/sps_frame.sv
module sps_frame #(
    parameter int AW       = 5,
    parameter int RW       = 5,
    parameter int CMD_BITS = 8,
    parameter int DBITS    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sdi_s,
    input  logic [RW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [RW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int FRAME = CMD_BITS + DBITS;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0] CMDL_C  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] DSTRT_C = CNT_W'(CMD_BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rw;
        logic [AW-1:0]    addr;
        logic [RW-1:0]    wdat;
        logic [DBITS-1:0] rsh;
        logic             sdo;
        logic             oe;
        logic             wr;
    } frame_t;

    frame_t q, d;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (!cs_act) begin
            d.cnt = '0;
            d.rw  = 1'b0;
            d.oe  = 1'b0;
            d.sdo = 1'b0;
        end else if (sclk_rise && (q.cnt < FRAME_C)) begin
            if (q.cnt == '0) d.rw = sdi_s;
            for (int i = 0; i < AW; i++) begin
                if (q.cnt == CNT_W'(i + 1)) d.addr[i] = sdi_s;
            end
            for (int i = 0; i < RW; i++) begin
                if (q.cnt == CNT_W'(CMD_BITS + i)) d.wdat[i] = sdi_s;
            end
            if ((q.cnt == CMDL_C) && q.rw) d.rsh = DBITS'(rd_data);
            if (q.cnt == LAST_C) begin
                d.oe  = 1'b0;
                d.sdo = 1'b0;
                d.wr  = !q.rw;
            end
            d.cnt = q.cnt + 1'b1;
        end else if (sclk_fall && q.rw && (q.cnt >= DSTRT_C) && (q.cnt < FRAME_C)) begin
            d.sdo = q.rsh[0];
            d.rsh = q.rsh >> 1;
            d.oe  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr = q.addr;
    assign wr_addr = q.addr;
    assign wr_data = q.wdat;
    assign wr_en   = q.wr;
    assign sdo     = q.sdo;
    assign sdo_oe  = q.oe;

    // R4
    sdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !q.oe);
    // R4
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> q.rw);
    // R8
    abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !q.wr);
    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);
    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FRAME_C);
endmodule

// File: rtl/sps_regs.sv
module sps_regs
    import sps_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int RPC   = 8,
    parameter int AW    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NCH-1:0]     los_i,
    input  logic [NCH-1:0]     alos_i,
    input  logic [NCH-1:0]     dlos_i,
    input  logic [NCH-1:0]     dmo_i,
    output logic [NCH*REG_W-1:0] tx_cfg_o,
    output logic [NCH*REG_W-1:0] rxl_cfg_o,
    output logic [NCH*REG_W-1:0] rxo_cfg_o,
    output logic [NCH*REG_W-1:0] loop_cfg_o
);
    localparam int IDX_W = $clog2(RPC);
    localparam int CH_W  = AW - IDX_W;

    typedef logic [NCH-1:0][NCTL-1:0][REG_W-1:0] bank_t;
    typedef struct packed {
        bank_t cfg;
    } regs_t;

    regs_t q, d;
    bank_t dflt;

    logic [CH_W-1:0]  wch, rch;
    logic [IDX_W-1:0] widx, ridx;

    assign wch  = wr_addr[AW-1:IDX_W];
    assign widx = wr_addr[IDX_W-1:0];
    assign rch  = rd_addr[AW-1:IDX_W];
    assign ridx = rd_addr[IDX_W-1:0];

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NCTL; k++) begin
                dflt[c][k] = ctl_default(k);
            end
        end
    end

    always_comb begin
        d = q;
        if (reg_rst) begin
            d.cfg = dflt;
        end else if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                for (int k = 0; k < NCTL; k++) begin
                    if ((wch == CH_W'(c)) && (widx == IDX_W'(k + 1)))
                        d.cfg[c][k] = wr_data & ctl_mask(k);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.cfg <= dflt;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rch == CH_W'(c)) begin
                if (ridx == '0)
                    rd_data = REG_W'({dmo_i[c], dlos_i[c], alos_i[c], los_i[c]});
                for (int k = 0; k < NCTL; k++) begin
                    if (ridx == IDX_W'(k + 1)) rd_data = q.cfg[c][k];
                end
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign tx_cfg_o  [c*REG_W +: REG_W] = q.cfg[c][0];
        assign rxl_cfg_o [c*REG_W +: REG_W] = q.cfg[c][1];
        assign rxo_cfg_o [c*REG_W +: REG_W] = q.cfg[c][2];
        assign loop_cfg_o[c*REG_W +: REG_W] = q.cfg[c][3];
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !reg_rst) |=> $stable(q.cfg));
    // R5
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_rst && (widx == '0)) |=> $stable(q.cfg));
    // R9
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst |=> (q.cfg == dflt));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import sps_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int REGS_PER_CH = 8,
    parameter int CMD_BITS    = 8,
    parameter int DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_rst,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    output logic                 sdo,
    output logic                 sdo_oe,
    input  logic [NCH-1:0]       los_i,
    input  logic [NCH-1:0]       alos_i,
    input  logic [NCH-1:0]       dlos_i,
    input  logic [NCH-1:0]       dmo_i,
    output logic [NCH*REG_W-1:0] tx_cfg_o,
    output logic [NCH*REG_W-1:0] rxl_cfg_o,
    output logic [NCH*REG_W-1:0] rxo_cfg_o,
    output logic [NCH*REG_W-1:0] loop_cfg_o
);
    localparam int AW = $clog2(NCH * REGS_PER_CH);

    logic [2:0]       pins_s;
    logic             sclk_prev_q;
    logic             cs_act, sclk_rise, sclk_fall;
    logic             wr_en;
    logic [AW-1:0]    wr_addr, rd_addr;
    logic [REG_W-1:0] wr_data, rd_data;

    sps_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdi}),
        .sync_o  (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= pins_s[1];
    end

    assign cs_act    = !pins_s[2];
    assign sclk_rise =  pins_s[1] && !sclk_prev_q;
    assign sclk_fall = !pins_s[1] &&  sclk_prev_q;

    sps_frame #(
        .AW(AW), .RW(REG_W), .CMD_BITS(CMD_BITS), .DBITS(DATA_BITS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (pins_s[0]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    sps_regs #(.NCH(NCH), .RPC(REGS_PER_CH), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rst    (reg_rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .los_i      (los_i),
        .alos_i     (alos_i),
        .dlos_i     (dlos_i),
        .dmo_i      (dmo_i),
        .tx_cfg_o   (tx_cfg_o),
        .rxl_cfg_o  (rxl_cfg_o),
        .rxo_cfg_o  (rxo_cfg_o),
        .loop_cfg_o (loop_cfg_o)
    );
endmodule

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
    localparam int NCH = 4;
    localparam int RW  = 5;
    localparam int H   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_rst = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NCH-1:0] los_i = '0, alos_i = '0, dlos_i = '0, dmo_i = '0;
    logic [NCH*RW-1:0] tx_cfg_o, rxl_cfg_o, rxo_cfg_o, loop_cfg_o;

    always #2 clk = ~clk;

    serial_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_rst(reg_rst),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .los_i(los_i), .alos_i(alos_i), .dlos_i(dlos_i), .dmo_i(dmo_i),
        .tx_cfg_o(tx_cfg_o), .rxl_cfg_o(rxl_cfg_o),
        .rxo_cfg_o(rxo_cfg_o), .loop_cfg_o(loop_cfg_o)
    );

    int checks = 0, fails = 0;
    int model [32];
    int rd_val, oe_miss, oe_after;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int mask_of(input int idx);
        case (idx)
            1: return 15;
            2: return 7;
            3: return 15;
            4: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int expect_rd(input int a);
        int c = a / 8;
        if ((a % 8) == 0)
            return int'(los_i[c]) | (int'(alos_i[c]) << 1) |
                   (int'(dlos_i[c]) << 2) | (int'(dmo_i[c]) << 3);
        return model[a];
    endfunction

    task automatic hc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_defaults();
        for (int a = 0; a < 32; a++) model[a] = ((a % 8) == 2) ? 1 : 0;
    endtask

    task automatic xfer(input bit rd, input int addr, input int data, input int nbits);
        rd_val = 0; oe_miss = 0;
        cs_n = 1'b0;
        hc(H);
        for (int i = 0; i < nbits; i++) begin
            int b;
            if (i == 0)                b = rd ? 1 : 0;
            else if (i <= 5)           b = (addr >> (i - 1)) & 1;
            else if (i < 8)            b = 1;
            else if (i < 16)           b = (data >> (i - 8)) & 1;
            else                       b = 1;
            sdi = b[0];
            hc(H);
            if (i >= 8 && i < 16) begin
                rd_val |= int'(sdo) << (i - 8);
                if (rd && !sdo_oe) oe_miss++;
            end
            if (i >= 16 && sdo_oe) oe_miss++;
            sclk = 1'b1;
            hc(H);
            sclk = 1'b0;
        end
        hc(H);
        oe_after = int'(sdo_oe);
        cs_n = 1'b1;
        hc(2 * H);
    endtask

    task automatic check_outputs(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(int'(tx_cfg_o[c*RW +: RW])   == model[c*8+1], {tag, " R7 tx"},   int'(tx_cfg_o[c*RW +: RW]),   model[c*8+1]);
            chk(int'(rxl_cfg_o[c*RW +: RW])  == model[c*8+2], {tag, " R7 rxl"},  int'(rxl_cfg_o[c*RW +: RW]),  model[c*8+2]);
            chk(int'(rxo_cfg_o[c*RW +: RW])  == model[c*8+3], {tag, " R7 rxo"},  int'(rxo_cfg_o[c*RW +: RW]),  model[c*8+3]);
            chk(int'(loop_cfg_o[c*RW +: RW]) == model[c*8+4], {tag, " R7 loop"}, int'(loop_cfg_o[c*RW +: RW]), model[c*8+4]);
        end
    endtask

    task automatic sweep(input int seed, input bit inv);
        for (int a = 0; a < 32; a++) begin
            int w = (a * 37 + seed) & 255;
            if (inv) w = (~w) & 255;
            xfer(1'b0, a, w, 16);
            if ((a % 8) >= 1 && (a % 8) <= 4) model[a] = w & mask_of(a % 8);
        end
        for (int a = 0; a < 32; a++) begin
            int e = expect_rd(a);
            xfer(1'b1, a, 0, 16);
            // R1 R2 R5 R6: full read word including masked and reserved bits
            chk(rd_val == e, "R1/R2 R5 R6 readback", rd_val, e);
            // R3: bits after D4 read zero
            chk((rd_val >> 5) == 0, "R3 tail zero", rd_val >> 5, 0);
            // R4: driven in the data phase, released after completion
            chk(oe_miss == 0 && oe_after == 0, "R4 sdo_oe", oe_miss * 2 + oe_after, 0);
        end
        check_outputs("sweep");
    endtask

    initial begin
        #(150000 * 4);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_defaults();
        hc(5);
        rst_n = 1'b1;
        hc(5);
        // R9 reset state and R4 idle release
        chk(sdo_oe == 1'b0, "R4 idle oe", int'(sdo_oe), 0);
        check_outputs("reset R9");

        los_i = 4'b1010; alos_i = 4'b0110; dlos_i = 4'b0011; dmo_i = 4'b1100;
        sweep(11, 1'b0);
        los_i = 4'b0101; alos_i = 4'b1001; dlos_i = 4'b1100; dmo_i = 4'b0011;
        sweep(11, 1'b1);

        // R6: upper data bits discarded
        xfer(1'b0, 17, 255, 16);
        model[17] = 15;
        xfer(1'b1, 17, 0, 16);
        chk(rd_val == 15, "R6 high data bits", rd_val, 15);

        // R8: frame cut off after twelve bits leaves target unchanged
        xfer(1'b0, 9, (~model[9]) & 15, 12);
        xfer(1'b1, 9, 0, 16);
        chk(rd_val == model[9], "R8 abort", rd_val, model[9]);
        chk(int'(tx_cfg_o[RW +: RW]) == model[9], "R8 abort output", int'(tx_cfg_o[RW +: RW]), model[9]);

        // R10: extra clocks after the sixteenth bit are ignored
        xfer(1'b0, 26, 6, 22);
        model[26] = 6;
        xfer(1'b1, 26, 0, 22);
        chk(rd_val == 6, "R10 extra clocks write", rd_val, 6);
        chk(oe_miss == 0 && oe_after == 0, "R10 oe stays low", oe_miss * 2 + oe_after, 0);

        // R9: register reset
        @(negedge clk); reg_rst = 1'b1;
        @(negedge clk); reg_rst = 1'b0;
        hc(2);
        model_defaults();
        check_outputs("R9 reg_rst");
        xfer(1'b1, 10, 0, 16);
        chk(rd_val == 1, "R9 readback default", rd_val, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule